// File: doc/BRIEF.md
# Trimmed One-Second Divider with Periodic Correction

This block turns a slow oscillator enable (nominally 32768 pulses per second) into a one-cycle seconds tick and a minute strobe. It trims the result digitally, and the oscillator itself is never touched. The divider has two stages. A prescaler counts oscillator enables in groups of `PRE_DIV`, and a second-stage counter counts those groups up to `SEC_DIV`. Corrections change only the terminal count of the second stage. A second is therefore shortened or lengthened in whole prescaler groups.

The trim setting is a 6-bit word. The upper bit is the direction and the lower five bits are a magnitude N. Corrections repeat on a 64-minute cycle. In each of the first 2N minutes of that cycle, the opening second of the minute is altered. Corrections never reach past minute 61. A positive setting removes two prescaler groups from the second (256 oscillator pulses by default), which makes the clock run faster. A negative setting adds one group (128 pulses), which makes it run slower. The word is captured only when a new correction cycle begins, or continuously while the block is stopped. The calendar that consumes the ticks sits outside this block.

Top module: `rtc_trim_divider`

## Requirements
- R1: With magnitude 0, under either direction bit, every second lasts exactly PRE_DIV*SEC_DIV oscillator enables.
- R2: Only clock cycles with `osc_en` high advance the divider. `sec_tick` is a one-cycle pulse, registered in the cycle after the enable that completes a second.
- R3: `min_tick` is high together with every SEC_PER_MIN-th `sec_tick` of a running period, and at no other time.
- R4: With direction bit `cal_word[5]`=1 and magnitude N=`cal_word[4:0]`>0, the first second of each minute m < 2N in the cycle lasts PRE_DIV*(SEC_DIV-POS_STEPS) enables. All other seconds are nominal.
- R5: With direction bit 0 and N>0, the first second of each minute m < 2N lasts PRE_DIV*(SEC_DIV+NEG_STEPS) enables.
- R6: No minute with index MIN_PER_CYCLE-2 or above is ever corrected, whatever the magnitude.
- R7: The calibration word is captured at the start of each correction cycle. A change in the middle of a cycle takes effect only from the next cycle.
- R8: While `run` is low, no ticks are produced and every counter is held at zero. After `run` rises, the first second is a full second counted from the first enable.
- R9: Synchronous reset clears both outputs and clears the captured calibration to no correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One oscillator period elapsed |
| run | input | 1 | High to count, low to hold counters at zero |
| cal_word | input | MAG_W+1 | Bit MAG_W is the direction (1 = faster); the lower bits are the magnitude |
| sec_tick | output | 1 | One-cycle pulse per second |
| min_tick | output | 1 | One-cycle pulse at the end of each minute |

## Verification
The bench builds the block with PRE_DIV=4, SEC_DIV=8, SEC_PER_MIN=4 and MIN_PER_CYCLE=8. A nominal second is then 32 enables and a full correction cycle is 1024. Shortened seconds last 24 enables and lengthened ones last 36. With these values the bench can run complete 64-minute-style cycles many times over. That brings the cap at minute 6, the cycle-boundary capture of the word, and stop/restart mid-second all within reach. Gapped enable patterns are also run against the per-clock reference model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE  = 2'd0,
    TRIM_SHORT = 2'd1,
    TRIM_LONG  = 2'd2
  } trim_e;
endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
  parameter int PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic osc_en,
  output logic sub_en
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt;

  assign sub_en = run & osc_en & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (osc_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cal_second_div.sv
module cal_second_div
  import rtc_cal_pkg::*;
#(
  parameter int SEC_DIV   = 256,
  parameter int POS_STEPS = 2,
  parameter int NEG_STEPS = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  sub_en,
  input  trim_e trim,
  output logic  sec_pulse
);
  localparam int TW = $clog2(SEC_DIV + NEG_STEPS);

  logic [TW-1:0] cnt;
  logic [TW-1:0] term;

  always_comb begin
    unique case (trim)
      TRIM_SHORT: term = TW'(SEC_DIV - POS_STEPS - 1);
      TRIM_LONG:  term = TW'(SEC_DIV + NEG_STEPS - 1);
      default:    term = TW'(SEC_DIV - 1);
    endcase
  end

  assign sec_pulse = sub_en & (cnt == term);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (sub_en) cnt <= (cnt == term) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cal_cycle_ctrl.sv
module cal_cycle_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int MAG_W         = 5,
  parameter int CAL_MIN_LIMIT = 62
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           sec_pulse,
  input  logic [MAG_W:0] cal_word,
  output logic           min_end,
  output trim_e          trim
);
  localparam int SW = $clog2(SEC_PER_MIN);
  localparam int MW = $clog2(MIN_PER_CYCLE);

  logic [SW-1:0] sec_idx;
  logic [MW-1:0] min_idx;
  logic [MAG_W:0] cal_lat;
  logic [MAG_W:0] span;
  logic sec_last, min_last, cyc_end, in_window;

  assign sec_last = (sec_idx == SW'(SEC_PER_MIN - 1));
  assign min_last = (min_idx == MW'(MIN_PER_CYCLE - 1));
  assign min_end  = sec_pulse & sec_last;
  assign cyc_end  = min_end & min_last;

  assign span      = {cal_lat[MAG_W-1:0], 1'b0};
  assign in_window = (32'(min_idx) < 32'(span)) &&
                     (32'(min_idx) < 32'(CAL_MIN_LIMIT));

  always_comb begin
    if (sec_idx == '0 && in_window)
      trim = cal_lat[MAG_W] ? TRIM_SHORT : TRIM_LONG;
    else
      trim = TRIM_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sec_idx <= '0;
      min_idx <= '0;
    end else if (sec_pulse) begin
      sec_idx <= sec_last ? '0 : sec_idx + 1'b1;
      if (sec_last) min_idx <= min_last ? '0 : min_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cal_lat <= '0;
    else if (!run || cyc_end) cal_lat <= cal_word;
  end
endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtc_cal_pkg::*;
#(
  parameter int PRE_DIV       = 128,
  parameter int SEC_DIV       = 256,
  parameter int POS_STEPS     = 2,
  parameter int NEG_STEPS     = 1,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int MAG_W         = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           osc_en,
  input  logic           run,
  input  logic [MAG_W:0] cal_word,
  output logic           sec_tick,
  output logic           min_tick
);
  localparam int CAL_MIN_LIMIT = MIN_PER_CYCLE - 2;

  logic  sub_en, sec_pulse, min_end;
  trim_e trim;

  cal_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run), .osc_en(osc_en), .sub_en(sub_en)
  );

  cal_second_div #(
    .SEC_DIV(SEC_DIV), .POS_STEPS(POS_STEPS), .NEG_STEPS(NEG_STEPS)
  ) u_sec (
    .clk(clk), .rst(rst), .run(run), .sub_en(sub_en), .trim(trim),
    .sec_pulse(sec_pulse)
  );

  cal_cycle_ctrl #(
    .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE),
    .MAG_W(MAG_W), .CAL_MIN_LIMIT(CAL_MIN_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .sec_pulse(sec_pulse),
    .cal_word(cal_word), .min_end(min_end), .trim(trim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_tick <= 1'b0;
      min_tick <= 1'b0;
    end else begin
      sec_tick <= sec_pulse;
      min_tick <= min_end;
    end
  end
endmodule

// File: rtl/rtc_trim_checker.sv
module rtc_trim_checker
  import rtc_cal_pkg::*;
#(
  parameter int MAX_LEN = 128 * 257
) (
  input logic  clk,
  input logic  rst,
  input logic  osc_en,
  input logic  run,
  input logic  sec_tick,
  input logic  min_tick,
  input logic  sec_pulse,
  input trim_e trim
);
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst || !run) gap <= 0;
    else if (sec_tick) gap <= osc_en ? 1 : 0;
    else if (osc_en) gap <= gap + 1;
  end

  p_max_len_r5: assert property (@(posedge clk) disable iff (rst)
    gap <= MAX_LEN);

  p_tick_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(osc_en));

  p_min_with_sec_r3: assert property (@(posedge clk) disable iff (rst)
    min_tick |-> sec_tick);

  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sec_tick && !min_tick);

  p_trim_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(sec_pulse)) |-> $stable(trim));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> !sec_tick && !min_tick);
endmodule

bind rtc_trim_divider rtc_trim_checker #(
  .MAX_LEN(PRE_DIV * (SEC_DIV + NEG_STEPS))
) u_chk (
  .clk(clk), .rst(rst), .osc_en(osc_en), .run(run),
  .sec_tick(sec_tick), .min_tick(min_tick),
  .sec_pulse(sec_pulse), .trim(trim)
);

// File: tb/rtc_trim_divider_bench.sv
`timescale 1ns/1ps
module rtc_trim_divider_bench;
  localparam int PRE = 4, SDIV = 8, POS = 2, NEG = 1, SPM = 4, MPC = 8, MW = 5;
  localparam int NOM = PRE * SDIV;
  localparam int SHORT = PRE * (SDIV - POS);
  localparam int LONG = PRE * (SDIV + NEG);
  localparam int CYC = NOM * SPM * MPC;

  logic clk = 1'b0, rst = 1'b1, osc_en = 1'b1, run = 1'b0;
  logic [MW:0] cal_word = '0;
  logic sec_tick, min_tick;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_trim_divider #(
    .PRE_DIV(PRE), .SEC_DIV(SDIV), .POS_STEPS(POS), .NEG_STEPS(NEG),
    .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC), .MAG_W(MW)
  ) u_rtc_trim_divider (
    .clk(clk), .rst(rst), .osc_en(osc_en), .run(run), .cal_word(cal_word),
    .sec_tick(sec_tick), .min_tick(min_tick)
  );

  // Behavioural reference: counts enables per second, seconds, minutes.
  int m_cnt, m_s, m_m, m_mag, m_sgn, m_len;
  bit exp_sec = 0, exp_min = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_s = 0; m_m = 0; m_mag = 0; m_sgn = 0;
      exp_sec = 0; exp_min = 0;
    end else if (!run) begin
      m_cnt = 0; m_s = 0; m_m = 0;
      m_mag = int'(cal_word[MW-1:0]); m_sgn = int'(cal_word[MW]);
      exp_sec = 0; exp_min = 0;
    end else begin
      exp_sec = 0; exp_min = 0;
      if (osc_en) begin
        m_cnt++;
        m_len = NOM;
        if (m_s == 0 && m_m < 2 * m_mag && m_m < MPC - 2)
          m_len = m_sgn ? SHORT : LONG;
        if (m_cnt == m_len) begin
          m_cnt = 0; exp_sec = 1;
          if (m_s == SPM - 1) begin
            m_s = 0; exp_min = 1;
            if (m_m == MPC - 1) begin
              m_m = 0;
              m_mag = int'(cal_word[MW-1:0]); m_sgn = int'(cal_word[MW]);
            end else m_m++;
          end else m_s++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(sec_tick == exp_sec, "R2 sec_tick vs model", int'(sec_tick), int'(exp_sec));
      chk(min_tick == exp_min, "R3 min_tick vs model", int'(min_tick), int'(exp_min));
      cyc++;
      if (cyc > 150000) begin
        chk(0, "R2 watchdog expired", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic to_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick && n < 4000);
  endtask

  task automatic to_min(input int k, output int n);
    int c = 0;
    n = 0;
    while (c < k && n < 20000) begin
      @(negedge clk); n++;
      if (min_tick) c++;
    end
  endtask

  task automatic restart(input logic [MW:0] w);
    @(negedge clk); run = 1'b0; cal_word = w;
    @(negedge clk); run = 1'b1;
  endtask

  initial begin
    int n, n2, cnt;
    repeat (4) @(negedge clk);
    chk(sec_tick == 0 && min_tick == 0, "R9 outputs in reset", int'(sec_tick), 0);
    rst = 1'b0;
    @(negedge clk); run = 1'b1;
    for (int i = 0; i < SPM; i++) begin
      to_tick(n);
      chk(n == NOM, "R1 nominal second", n, NOM);
      chk(min_tick == (i == SPM - 1), "R3 minute strobe", int'(min_tick), int'(i == SPM - 1));
    end
    restart(6'b100000);
    to_min(MPC, n); chk(n == CYC, "R1 zero magnitude positive sign", n, CYC);
    restart(6'b100010);
    to_tick(n); chk(n == SHORT, "R4 shortened first second", n, SHORT);
    to_tick(n); chk(n == NOM, "R4 second two nominal", n, NOM);
    restart(6'b100010);
    to_min(MPC, n); chk(n == CYC - 4 * (NOM - SHORT), "R4 cycle length N=2", n, CYC - 4 * (NOM - SHORT));
    restart(6'b000001);
    to_tick(n); chk(n == LONG, "R5 lengthened first second", n, LONG);
    restart(6'b000001);
    to_min(MPC, n); chk(n == CYC + 2 * (LONG - NOM), "R5 cycle length N=1", n, CYC + 2 * (LONG - NOM));
    restart(6'b111111);
    to_min(MPC, n); chk(n == CYC - (MPC - 2) * (NOM - SHORT), "R6 capped cycle", n, CYC - (MPC - 2) * (NOM - SHORT));
    to_min(MPC, n); chk(n == CYC - (MPC - 2) * (NOM - SHORT), "R6 capped second cycle", n, CYC - (MPC - 2) * (NOM - SHORT));
    restart(6'b100010);
    to_tick(n); cal_word = 6'b000000;
    to_min(MPC, n2);
    chk(n + n2 == CYC - 4 * (NOM - SHORT), "R7 mid-cycle change ignored", n + n2, CYC - 4 * (NOM - SHORT));
    to_min(MPC, n); chk(n == CYC, "R7 new word next cycle", n, CYC);
    repeat (10) @(negedge clk);
    run = 1'b0; cnt = 0;
    repeat (100) begin @(negedge clk); if (sec_tick || min_tick) cnt++; end
    chk(cnt == 0, "R8 no ticks while stopped", cnt, 0);
    run = 1'b1;
    to_tick(n); chk(n == NOM, "R8 full second after restart", n, NOM);
    osc_en = 1'b0; cnt = 0;
    repeat (200) begin @(negedge clk); if (sec_tick) cnt++; end
    chk(cnt == 0, "R2 no progress without enable", cnt, 0);
    restart(6'b100011);
    repeat (3000) begin @(negedge clk); osc_en = ($urandom % 3) != 0; end
    restart(6'b000010);
    repeat (3000) begin @(negedge clk); osc_en = ($urandom % 4) != 0; end
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sec_tick == 0 && min_tick == 0, "R9 outputs after reset", int'(sec_tick), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule